// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This core is a small multi-cycle processor built around one 8-bit accumulator. It also holds an 8-bit program counter, a carry flag and a zero flag. Each 12-bit instruction has a 4-bit opcode in bits 11:8 and an 8-bit operand in bits 7:0. The operand is either an immediate value or a data-memory address.

A microcode sequencer controls every instruction. On each clock it looks up a control word in a table indexed by the opcode and the current microstep. Every instruction starts with a fetch step and a decode step, which also advances the PC. Most opcodes then take one execute step. The table is filled by a function, so a reserved opcode can later get its own micro-sequence without any change to the datapath.

The core reads instructions from a program memory port and reads or writes a 256-byte data RAM. Both memories are read combinationally: read data must be valid in the same cycle as the address. The core drives an output register with a one-cycle valid strobe and signals when it has halted.

Top module: `acc_cpu_core`

## Requirements
- R1: While rst_ni is low, and after it is released, the core starts clean. The PC reads 0 on pmem_addr_o, out_data_o is 0, out_valid_o is 0 and halted_o is 0. Execution restarts at the fetch step, and a reset in the middle of a program behaves the same way.
- R2: Instruction fetch and timing:
  - The instruction is fetched from pmem_addr_o = PC. The opcode is bits 11:8 and the operand is bits 7:0.
  - Opcode 0000, the reserved opcodes and opcode 1111 take 2 cycles.
  - Every other opcode takes 3 cycles.
  - The PC advances by one in the second cycle of each instruction, except for 1111.
- R3: Loads and store:
  - 0101 loads the operand into the accumulator.
  - 0001 loads the accumulator from RAM at the operand address.
  - 0100 writes the accumulator to RAM at the operand address.
- R4: 0010 adds the RAM byte at the operand address to the accumulator, and 0011 subtracts it.
  - Carry is the 9th bit of the sum. Subtraction is computed as A + ~B + 1, so carry set means no borrow.
  - Zero is set when the 8-bit result is 0.
- R5: Carry and zero change only on 0010 and 0011. Every other instruction, including 0101 and 0001, leaves both flags unchanged.
- R6: Jumps:
  - 0110 sets the PC to the operand.
  - 0111 does so only when carry is set, and 1000 only when zero is set. When the condition is false, the PC stays at the incremented value.
- R7: 1110 copies the accumulator into out_data_o. out_valid_o is high for exactly the one cycle after the execute step.
- R8: 1111 sets halted_o. From then until reset, pmem_addr_o, the output register and the RAM stay unchanged.
- R9: Opcodes 1001 to 1101 and 0000 act as no-ops, whatever their operand bits hold. They leave the accumulator, flags and RAM unchanged, and the PC only advances.
- R10: ram_we_o is high only in the execute step of 0100. In that cycle ram_addr_o equals the operand and ram_wdata_o equals the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pmem_addr_o | output | 8 | Program memory address (PC) |
| pmem_data_i | input | 12 | Instruction word at pmem_addr_o, same cycle |
| ram_addr_o | output | 8 | Data RAM address (operand field) |
| ram_rdata_i | input | 8 | Data RAM read data at ram_addr_o, same cycle |
| ram_wdata_o | output | 8 | Data RAM write data |
| ram_we_o | output | 1 | Data RAM write enable, takes effect at the clock edge |
| out_data_o | output | 8 | Output register |
| out_valid_o | output | 1 | One-cycle strobe on a new output value |
| halted_o | output | 1 | Core has executed a halt |

## Verification
The assertions assume three things about the environment:
- Both memories answer combinationally in the cycle an address is presented.
- A RAM write takes effect at the clock edge that ends the store step.
- Reset is held low for at least one clock edge.

The bench models both memories as plain arrays that are read continuously and written on the rising edge. It drives reset only at falling edges, for several cycles. Every program it runs ends in a halt opcode, and unused program locations are filled with halts, so execution never runs into undefined words.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OP_W   = 4;
  localparam int STEP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'h0, OP_LDA = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
    OP_STA = 4'h4, OP_LDI = 4'h5, OP_JMP = 4'h6, OP_JC  = 4'h7,
    OP_JZ  = 4'h8, OP_OUT = 4'hE, OP_HLT = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {JMP_NONE, JMP_ALWAYS, JMP_C, JMP_Z} jmp_e;
  typedef enum logic [2:0] {ACC_HOLD, ACC_RAM, ACC_IMM, ACC_ADD, ACC_SUB} acc_e;

  typedef struct packed {
    logic ir_ld;
    logic pc_inc;
    jmp_e jmp;
    acc_e acc;
    logic flag_ld;
    logic ram_we;
    logic out_ld;
    logic halt;
    logic last;
  } ctrl_t;

  // Microcode: step 0 fetch, step 1 decode + PC advance, step 2 execute.
  function automatic ctrl_t ucode_word(logic [OP_W-1:0] op, logic [STEP_W-1:0] step);
    ctrl_t w;
    w = '0;
    unique case (step)
      2'd0: w.ir_ld = 1'b1;
      2'd1: begin
        if (op == OP_HLT) begin
          w.halt = 1'b1;
          w.last = 1'b1;
        end else begin
          w.pc_inc = 1'b1;
          w.last   = !(op inside {OP_LDA, OP_ADD, OP_SUB, OP_STA, OP_LDI,
                                  OP_JMP, OP_JC, OP_JZ, OP_OUT});
        end
      end
      2'd2: begin
        w.last = 1'b1;
        case (op)
          OP_LDA: w.acc = ACC_RAM;
          OP_ADD: begin w.acc = ACC_ADD; w.flag_ld = 1'b1; end
          OP_SUB: begin w.acc = ACC_SUB; w.flag_ld = 1'b1; end
          OP_STA: w.ram_we = 1'b1;
          OP_LDI: w.acc = ACC_IMM;
          OP_JMP: w.jmp = JMP_ALWAYS;
          OP_JC:  w.jmp = JMP_C;
          OP_JZ:  w.jmp = JMP_Z;
          OP_OUT: w.out_ld = 1'b1;
          default: ;
        endcase
      end
      default: w.last = 1'b1;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         zero_o
);
  logic [W:0]   sum;
  logic [W-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + (W+1)'(sub_i);
  assign res_o   = sum[W-1:0];
  assign carry_o = sum[W];
  assign zero_o  = (sum[W-1:0] == '0);
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o,
  output logic            halted_o
);
  localparam int ROM_N = 2 ** (OP_W + STEP_W);

  ctrl_t             rom [ROM_N];
  ctrl_t             word;
  logic [STEP_W-1:0] step_q;
  logic              halted_q;

  for (genvar gi = 0; gi < ROM_N; gi++) begin : g_rom
    assign rom[gi] = ucode_word(OP_W'(gi >> STEP_W), STEP_W'(gi));
  end

  assign word     = rom[{op_i, step_q}];
  assign ctrl_o   = halted_q ? '0 : word;
  assign halted_o = halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      halted_q <= word.halt;
      step_q   <= word.last ? '0 : step_q + 1'b1;
    end
  end

  // R2
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q != 2'd3);

  // R8
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> halted_q && step_q == '0);
endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  ctrl_t                  ctrl_i,
  input  logic [OP_W+ADDR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]      ram_rdata_i,
  output logic [OP_W-1:0]        op_o,
  output logic [ADDR_W-1:0]      pc_o,
  output logic [ADDR_W-1:0]      ram_addr_o,
  output logic [DATA_W-1:0]      ram_wdata_o,
  output logic                   ram_we_o,
  output logic [DATA_W-1:0]      out_data_o,
  output logic                   out_valid_o
);
  localparam int IW = OP_W + ADDR_W;

  logic [IW-1:0]     ir_q;
  logic [ADDR_W-1:0] pc_q, operand;
  logic [DATA_W-1:0] acc_q, out_q, alu_res;
  logic              c_q, z_q, alu_c, alu_z, take, out_vld_q;

  assign operand = ir_q[ADDR_W-1:0];
  assign op_o    = ir_q[IW-1:ADDR_W];

  acc_cpu_alu #(.W(DATA_W)) alu_i (
    .a_i    (acc_q),
    .b_i    (ram_rdata_i),
    .sub_i  (ctrl_i.acc == ACC_SUB),
    .res_o  (alu_res),
    .carry_o(alu_c),
    .zero_o (alu_z)
  );

  always_comb begin
    unique case (ctrl_i.jmp)
      JMP_ALWAYS: take = 1'b1;
      JMP_C:      take = c_q;
      JMP_Z:      take = z_q;
      default:    take = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q      <= '0;
      pc_q      <= '0;
      acc_q     <= '0;
      c_q       <= 1'b0;
      z_q       <= 1'b0;
      out_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      if (ctrl_i.ir_ld) ir_q <= instr_i;
      if (take)               pc_q <= operand;
      else if (ctrl_i.pc_inc) pc_q <= pc_q + 1'b1;
      case (ctrl_i.acc)
        ACC_RAM:          acc_q <= ram_rdata_i;
        ACC_IMM:          acc_q <= DATA_W'(operand);
        ACC_ADD, ACC_SUB: acc_q <= alu_res;
        default: ;
      endcase
      if (ctrl_i.flag_ld) begin
        c_q <= alu_c;
        z_q <= alu_z;
      end
      out_vld_q <= ctrl_i.out_ld;
      if (ctrl_i.out_ld) out_q <= acc_q;
    end
  end

  assign pc_o        = pc_q;
  assign ram_addr_o  = operand;
  assign ram_wdata_o = acc_q;
  assign ram_we_o    = ctrl_i.ram_we;
  assign out_data_o  = out_q;
  assign out_valid_o = out_vld_q;

  // R5
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.flag_ld |=> $stable({c_q, z_q}));

  // R7
  out_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_q |=> !out_vld_q);

  // R9
  reserved_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o inside {4'h0, [4'h9:4'hD]}) |-> (ctrl_i.acc == ACC_HOLD && !ctrl_i.ram_we
                                           && ctrl_i.jmp == JMP_NONE));
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  output logic [ADDR_W-1:0]      pmem_addr_o,
  input  logic [OP_W+ADDR_W-1:0] pmem_data_i,
  output logic [ADDR_W-1:0]      ram_addr_o,
  input  logic [DATA_W-1:0]      ram_rdata_i,
  output logic [DATA_W-1:0]      ram_wdata_o,
  output logic                   ram_we_o,
  output logic [DATA_W-1:0]      out_data_o,
  output logic                   out_valid_o,
  output logic                   halted_o
);
  ctrl_t           ctrl;
  logic [OP_W-1:0] op;

  acc_cpu_seq seq_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .ctrl_o  (ctrl),
    .halted_o(halted_o)
  );

  acc_cpu_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .instr_i    (pmem_data_i),
    .ram_rdata_i(ram_rdata_i),
    .op_o       (op),
    .pc_o       (pmem_addr_o),
    .ram_addr_o (ram_addr_o),
    .ram_wdata_o(ram_wdata_o),
    .ram_we_o   (ram_we_o),
    .out_data_o (out_data_o),
    .out_valid_o(out_valid_o)
  );

  // R10
  we_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> !halted_o && !out_valid_o);

  // R8
  pc_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(pmem_addr_o) && !ram_we_o && !out_valid_o);
endmodule

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  pmem_addr, ram_addr, ram_wdata, ram_rdata, out_data;
  logic [11:0] pmem_data;
  logic        ram_we, out_valid, halted;

  logic [11:0] pmem [256];
  logic [7:0]  dram [256];

  assign pmem_data = pmem[pmem_addr];
  assign ram_rdata = dram[ram_addr];
  always @(posedge clk) if (ram_we) dram[ram_addr] <= ram_wdata;

  acc_cpu_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .pmem_addr_o(pmem_addr), .pmem_data_i(pmem_data),
    .ram_addr_o(ram_addr), .ram_rdata_i(ram_rdata),
    .ram_wdata_o(ram_wdata), .ram_we_o(ram_we),
    .out_data_o(out_data), .out_valid_o(out_valid), .halted_o(halted)
  );

  int checks = 0, fails = 0;
  bit cmp_en = 0;
  logic [7:0] got_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model, advanced on every rising edge.
  logic [7:0]  m_pc, m_a, m_out;
  logic [11:0] m_ir;
  logic [7:0]  m_ram [256];
  int          m_step;
  bit          m_c, m_z, m_halt, m_vld;

  task automatic model_step();
    logic [3:0] op;
    logic [8:0] s;
    logic [7:0] b;
    if (!rst_ni) begin
      m_pc = 0; m_a = 0; m_out = 0; m_ir = 0; m_step = 0;
      m_c = 0; m_z = 0; m_halt = 0; m_vld = 0;
      return;
    end
    m_vld = 0;
    if (m_halt) return;
    op = m_ir[11:8];
    b  = m_ram[m_ir[7:0]];
    if (m_step == 0) begin
      m_ir = pmem[m_pc];
      m_step = 1;
    end else if (m_step == 1) begin
      if (op == 4'hF) begin
        m_halt = 1; m_step = 0;
      end else begin
        m_pc = m_pc + 8'd1;
        m_step = (op == 4'h0 || (op >= 4'h9 && op <= 4'hD)) ? 0 : 2;
      end
    end else begin
      case (op)
        4'h1: m_a = b;
        4'h2: begin s = {1'b0, m_a} + {1'b0, b}; m_a = s[7:0]; m_c = s[8]; m_z = (s[7:0] == 0); end
        4'h3: begin s = {1'b0, m_a} + {1'b0, ~b} + 9'd1; m_a = s[7:0]; m_c = s[8]; m_z = (s[7:0] == 0); end
        4'h4: m_ram[m_ir[7:0]] = m_a;
        4'h5: m_a = m_ir[7:0];
        4'h6: m_pc = m_ir[7:0];
        4'h7: if (m_c) m_pc = m_ir[7:0];
        4'h8: if (m_z) m_pc = m_ir[7:0];
        4'hE: begin m_out = m_a; m_vld = 1; end
        default: ;
      endcase
      m_step = 0;
    end
  endtask

  always @(posedge clk) model_step();

  always @(negedge clk) begin
    if (cmp_en) begin
      bit exp_we;
      exp_we = !m_halt && m_step == 2 && m_ir[11:8] == 4'h4;
      check(pmem_addr == m_pc, "R2 pc", pmem_addr, m_pc);
      check(out_data == m_out, "R7 out_data", out_data, m_out);
      check(out_valid == m_vld, "R7 out_valid", out_valid, m_vld);
      check(halted == m_halt, "R8 halted", halted, m_halt);
      check(ram_we == exp_we, "R10 ram_we", ram_we, exp_we);
      if (exp_we) begin
        check(ram_addr == m_ir[7:0], "R10 ram_addr", ram_addr, m_ir[7:0]);
        check(ram_wdata == m_a, "R10 ram_wdata", ram_wdata, m_a);
      end
      if (out_valid) got_q.push_back(out_data);
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      pmem[i] = 12'hF00;
      dram[i] = 8'h00;
      m_ram[i] = 8'h00;
    end
    got_q.delete();
  endtask

  task automatic do_reset();
    cmp_en = 0;
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(pmem_addr == 0, "R1 pc", pmem_addr, 0);
    check(out_data == 0, "R1 out_data", out_data, 0);
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(halted == 0, "R1 halted", halted, 0);
    rst_ni = 1'b1;
    @(posedge clk);
    cmp_en = 1;
  endtask

  task automatic run_to_halt();
    int n = 0;
    while (!halted && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(halted, "R8 reached halt", halted, 1);
    repeat (12) @(negedge clk);
  endtask

  task automatic check_outs(input logic [7:0] exp[$], input string req);
    check(got_q.size() == exp.size(), req, got_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got_q.size(); i++)
      check(got_q[i] == exp[i], req, got_q[i], exp[i]);
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] exp1[$];
    logic [7:0] exp2[$];
    // Program 1: loads, store, arithmetic, branches, reserved, OUT, HLT.
    clear_mem();
    pmem[0]  = 12'h505; pmem[1]  = 12'h410; pmem[2]  = 12'h503; pmem[3]  = 12'h210;
    pmem[4]  = 12'hE00; pmem[5]  = 12'h310; pmem[6]  = 12'hE00; pmem[7]  = 12'h709;
    pmem[8]  = 12'hEFF; pmem[9]  = 12'h110; pmem[10] = 12'h310; pmem[11] = 12'h80D;
    pmem[12] = 12'hF00; pmem[13] = 12'hE00; pmem[14] = 12'h502; pmem[15] = 12'h310;
    pmem[16] = 12'h711; pmem[17] = 12'hE00; pmem[18] = 12'h814; pmem[19] = 12'h9A5;
    pmem[20] = 12'hE00; pmem[21] = 12'h5FF; pmem[22] = 12'h420; pmem[23] = 12'h220;
    pmem[24] = 12'h501; pmem[25] = 12'h71B; pmem[26] = 12'hE00; pmem[27] = 12'hE00;
    pmem[28] = 12'h0AB; pmem[29] = 12'hD3C; pmem[30] = 12'h620; pmem[31] = 12'hE00;
    pmem[32] = 12'hF77;
    do_reset();
    run_to_halt();
    // R4 R6 R9: 8, 3 (carry set), 0 (zero jump), FD twice (borrow, reserved no-op), 1 (carry kept past LDI)
    exp1 = '{8'h08, 8'h03, 8'h00, 8'hFD, 8'hFD, 8'h01};
    check_outs(exp1, "R4 R6 R9 output sequence");
    check(dram[8'h10] == 8'h05, "R3 store 0x10", dram[8'h10], 8'h05);
    check(dram[8'h20] == 8'hFF, "R3 store 0x20", dram[8'h20], 8'hFF);
    check(pmem_addr == 8'd32, "R8 pc frozen at halt", pmem_addr, 32);
    check(dram[8'hA5] == 8'h00, "R9 reserved operand ignored", dram[8'hA5], 0);

    // Program 2: ADD with wrap to zero; LDI keeps flags; mid-run reset.
    clear_mem();
    pmem[0] = 12'h580; pmem[1] = 12'h401; pmem[2] = 12'h201; pmem[3] = 12'h805;
    pmem[4] = 12'hF00; pmem[5] = 12'hE00; pmem[6] = 12'h507; pmem[7] = 12'h809;
    pmem[8] = 12'hF00; pmem[9] = 12'hE00; pmem[10] = 12'hF00;
    do_reset();
    repeat (10) @(negedge clk);
    do_reset();
    got_q.delete();
    run_to_halt();
    // R5: zero flag from ADD survives LDI and still takes JZ.
    exp2 = '{8'h00, 8'h07};
    check_outs(exp2, "R5 output sequence");
    check(dram[8'h01] == 8'h80, "R3 store 0x01", dram[8'h01], 8'h80);
    check(pmem_addr == 8'd10, "R8 pc frozen at halt", pmem_addr, 10);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule